// File: doc/BRIEF.md
# Tagged Word Load/Store Unit

This block is the data-memory stage of a small coprocessor. The core hands it one operation at a time: a load or a store, a base register value holding a word address, the index of that base register, a signed 13-bit byte offset, the 16-bit store data and the program counter of the instruction. The block turns the byte offset into a word offset and adds it to the base, wrapping inside a 2048-word (8 KiB) space. It then performs one access on a word-wide memory port.

A store always writes a full 32-bit word. The low half carries the data. The high half carries a provenance tag made of the storing instruction's PC and the base-register index, so software can later tell which instruction produced any given word. A load returns only the low 16 bits of the addressed word.

The memory port is shared with a host, and the host always has priority. While the host requests the port, the coprocessor's access waits, and the operation takes one extra cycle for each cycle it is held off. A single-cycle `done` pulse tells the core that the operation is complete, so it can start its next fetch.

Top module: `tagstore_lsu`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `done` is 0 and the block makes no memory access (`mem_en` is 0 unless the host requests).
- R2: The word address is `(req_base + (req_off >>> 2)) mod 2048`. The shift is arithmetic, so the two low offset bits are dropped and negative offsets round toward minus infinity (a byte offset of -1 gives a word offset of -1).
- R3: A store writes the 32-bit word `{pc[10:0], 3'b000, idx[1:0], data[15:0]}`: PC in bits 31:21, zeros in bits 20:18, base index in bits 17:16 and data in bits 15:0.
- R4: A load presents bits 15:0 of the addressed word on `rdata` in the cycle `done` is high. Bits 31:16 have no effect on `rdata`.
- R5: With no host request, `done` is high in the fourth cycle after the clock edge that accepts `req_valid`. The operation issues exactly one memory access.
- R6: While `host_req` is high, the host owns the memory port (`host_gnt` high, host address, data and write enable on the port). The coprocessor access is held off, and each held-off cycle delays `done` by one cycle.
- R7: `done` is a single-cycle pulse.
- R8: `req_valid` is only accepted while the block is idle. A request raised during an operation starts no access and produces no `done`.
- R9: A load never writes memory. The addressed word is unchanged afterwards.
- R10: `rdata` changes only in the cycle a load completes. A store leaves it holding the last load result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start an operation (taken only when idle) |
| req_store | input | 1 | 1 = store, 0 = load |
| req_base | input | 11 | Base register value, word address |
| req_idx | input | 2 | Index of the base register |
| req_off | input | 13 | Signed byte offset |
| req_data | input | 16 | Store data |
| req_pc | input | 11 | PC of the instruction, in words |
| done | output | 1 | Operation complete pulse |
| rdata | output | 16 | Load result |
| host_req | input | 1 | Host requests the memory port |
| host_we | input | 1 | Host write enable |
| host_addr | input | 11 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_gnt | output | 1 | Host owns the port this cycle |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 11 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the access |

## Verification
A wrong latched address or a mis-formed tag does not show on `done`. It only appears as a wrong word in memory, and the bench reads that word back in the same cycle `done` rises. A sequencer state that slips or sticks is caught as a `done` pulse arriving one cycle early or late against the cycle count the bench predicts. Any spare or repeated completion shows as an unmatched `done` within a few cycles. A wrongly updated result register is caught at the next completion, because every store checks that `rdata` still holds the previous load value.

// File: rtl/lsu_pkg.sv
// Package: shared types for the tagged load/store unit.
// Assumes: one operation in flight at a time.
package lsu_pkg;

    // Sequencer phases of one memory operation
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_MEM  = 3'd2,
        PH_RESP = 3'd3,
        PH_DONE = 3'd4
    } lsu_phase_e;

endpackage

// File: rtl/lsu_agu.sv
// Module: lsu_agu
// Forms the word address from a base word address and a signed byte offset.
// The offset is shifted right arithmetically by two (floor division by 4).
// The sum wraps within 2**ADDR_W words.
// Assumes: OFF_W >= 3.
module lsu_agu #(
    parameter int ADDR_W = 11,
    parameter int OFF_W  = 13
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic signed [OFF_W-1:0] word_off;

    // Byte offset to word offset, keeping the sign
    always_comb word_off = $signed(off_i) >>> 2;

    // Modular add inside the word space
    always_comb addr_o = base_i + ADDR_W'(word_off);

endmodule

// File: rtl/lsu_tagger.sv
// Module: lsu_tagger
// Builds the stored word: PC and base index in the upper half, data in the lower half.
// Assumes: PC_W + IDX_W + DATA_W <= WORD_W; the gap between them is zero-filled.
module lsu_tagger #(
    parameter int WORD_W = 32,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2,
    parameter int PC_W   = 11
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int PAD_W = WORD_W - DATA_W - IDX_W - PC_W;

    // Concatenate provenance tag above the data
    always_comb word_o = {pc_i, {PAD_W{1'b0}}, idx_i, data_i};

endmodule

// File: rtl/lsu_seq.sv
// Module: lsu_seq
// Four-phase sequencer: address, memory, response, done.
// It waits in the memory phase until the arbiter grants the port.
// Assumes: start_i is only honoured in the idle phase.
module lsu_seq
    import lsu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic gnt_i,
    output logic capture_o,
    output logic form_o,
    output logic core_req_o,
    output logic resp_o,
    output logic done_o
);

    lsu_phase_e phase_q, phase_d;

    // Phase register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Next-phase selection
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (start_i) phase_d = PH_ADDR;
            PH_ADDR: phase_d = PH_MEM;
            PH_MEM:  if (gnt_i) phase_d = PH_RESP;
            PH_RESP: phase_d = PH_DONE;
            PH_DONE: phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase-decoded strobes
    always_comb begin
        capture_o  = (phase_q == PH_IDLE) && start_i;
        form_o     = (phase_q == PH_ADDR);
        core_req_o = (phase_q == PH_MEM);
        resp_o     = (phase_q == PH_RESP);
        done_o     = (phase_q == PH_DONE);
    end

    // R7: completion lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: completion comes two cycles after the single granted access
    p_done_after_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(gnt_i, 2));

endmodule

// File: rtl/lsu_arb.sv
// Module: lsu_arb
// Fixed-priority port mux: the host always wins, the core waits.
// Assumes: the memory returns read data one cycle after mem_en.
module lsu_arb #(
    parameter int ADDR_W = 11,
    parameter int WORD_W = 32
) (
    input  logic              host_req_i,
    input  logic              host_we_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [WORD_W-1:0] host_wdata_i,
    input  logic              core_req_i,
    input  logic              core_we_i,
    input  logic [ADDR_W-1:0] core_addr_i,
    input  logic [WORD_W-1:0] core_wdata_i,
    output logic              host_gnt_o,
    output logic              core_gnt_o,
    output logic              mem_en_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o
);

    // Grants: host first
    always_comb begin
        host_gnt_o = host_req_i;
        core_gnt_o = core_req_i && !host_req_i;
    end

    // Port steering
    always_comb begin
        mem_en_o    = host_req_i || core_req_i;
        mem_we_o    = host_req_i ? host_we_i    : (core_req_i && core_we_i);
        mem_addr_o  = host_req_i ? host_addr_i  : core_addr_i;
        mem_wdata_o = host_req_i ? host_wdata_i : core_wdata_i;
    end

endmodule

// File: rtl/tagstore_lsu.sv
// Module: tagstore_lsu
// Data-memory stage of a small coprocessor. Stores write a tagged word;
// loads return the low half of a word. Shares a memory port with a
// higher-priority host.
// Assumes: one operation at a time; the memory has one cycle of read latency.
module tagstore_lsu #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11,
    parameter int OFF_W  = 13,
    parameter int PC_W   = 11,
    parameter int IDX_W  = 2,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [DATA_W-1:0] req_data,
    input  logic [PC_W-1:0]   req_pc,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic              host_gnt,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);

    logic capture, form, core_req, resp, core_gnt;
    logic              store_q;
    logic [ADDR_W-1:0] base_q, addr_q, addr_c;
    logic [IDX_W-1:0]  idx_q;
    logic [OFF_W-1:0]  off_q;
    logic [DATA_W-1:0] data_q, rdata_q;
    logic [PC_W-1:0]   pc_q;
    logic [WORD_W-1:0] word_q, word_c;

    lsu_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (req_valid),
        .gnt_i      (core_gnt),
        .capture_o  (capture),
        .form_o     (form),
        .core_req_o (core_req),
        .resp_o     (resp),
        .done_o     (done)
    );

    lsu_agu #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agu (
        .base_i (base_q),
        .off_i  (off_q),
        .addr_o (addr_c)
    );

    lsu_tagger #(.WORD_W(WORD_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .PC_W(PC_W)) u_tag (
        .pc_i   (pc_q),
        .idx_i  (idx_q),
        .data_i (data_q),
        .word_o (word_c)
    );

    lsu_arb #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_arb (
        .host_req_i   (host_req),
        .host_we_i    (host_we),
        .host_addr_i  (host_addr),
        .host_wdata_i (host_wdata),
        .core_req_i   (core_req),
        .core_we_i    (store_q),
        .core_addr_i  (addr_q),
        .core_wdata_i (word_q),
        .host_gnt_o   (host_gnt),
        .core_gnt_o   (core_gnt),
        .mem_en_o     (mem_en),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata)
    );

    // Latch the request operands when the sequencer accepts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= 1'b0;
            base_q  <= '0;
            idx_q   <= '0;
            off_q   <= '0;
            data_q  <= '0;
            pc_q    <= '0;
        end else if (capture) begin
            store_q <= req_store;
            base_q  <= req_base;
            idx_q   <= req_idx;
            off_q   <= req_off;
            data_q  <= req_data;
            pc_q    <= req_pc;
        end
    end

    // Register the address and the tagged word in the address phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            word_q <= '0;
        end else if (form) begin
            addr_q <= addr_c;
            word_q <= word_c;
        end
    end

    // Capture the low half of read data when a load's response arrives
    always_ff @(posedge clk) begin
        if (!rst_n)                rdata_q <= '0;
        else if (resp && !store_q) rdata_q <= DATA_W'(mem_rdata);
    end

    assign rdata = rdata_q;

    // R9: a granted core access for a load never writes
    p_load_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_gnt && !store_q) |-> !mem_we);

    // R6: a held-off core access stays pending into the next cycle
    p_host_holds_core_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req && host_req) |=> core_req);

    // R10: the result moves only when a load completes
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_q) |-> (done && !store_q));

    // R1: no core access right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!done && !core_req));

endmodule

// File: tb/tagstore_lsu_tb.sv
module tagstore_lsu_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0;
    logic [10:0] req_base = '0, req_pc = '0;
    logic [1:0]  req_idx = '0;
    logic [12:0] req_off = '0;
    logic [15:0] req_data = '0;
    logic        done;
    logic [15:0] rdata;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [10:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_gnt, mem_en, mem_we;
    logic [10:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    tagstore_lsu u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_store(req_store), .req_base(req_base),
        .req_idx(req_idx), .req_off(req_off), .req_data(req_data), .req_pc(req_pc),
        .done(done), .rdata(rdata),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_gnt(host_gnt),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model, one cycle read latency
    logic [31:0] bmem [0:2047];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) bmem[mem_addr] <= mem_wdata;
            mem_rdata <= bmem[mem_addr];
        end
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          exp_cyc;
        bit          is_store;
        logic [15:0] exp_rdata;
        logic [10:0] addr;
        logic [31:0] exp_word;
        string       lat_tag;
        string       rd_tag;
        string       mem_tag;
    } item_t;

    item_t       sb[$];
    logic [31:0] shadow [int];
    logic [15:0] last_load = '0;
    int          n_chk = 0, n_fail = 0;
    bit          prev_done = 1'b0, finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [10:0] ea(input logic [10:0] base, input logic [12:0] off);
        int so;
        so = int'($signed(off));
        so = so >>> 2;
        return 11'((int'(base) + so) & 2047);
    endfunction

    // Monitor: pop and compare on every completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            chk(!prev_done, "R7", 32'(prev_done), 32'd0);
            if (sb.size() == 0) begin
                chk(1'b0, "R8 spurious done", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(cyc == it.exp_cyc, it.lat_tag, 32'(cyc), 32'(it.exp_cyc));
                chk(rdata === it.exp_rdata, it.rd_tag, 32'(rdata), 32'(it.exp_rdata));
                chk(bmem[it.addr] === it.exp_word, it.mem_tag, bmem[it.addr], it.exp_word);
            end
        end
        prev_done = done;
    end

    task automatic host_write(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        shadow[int'(a)] = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    // Driver: issue one operation, push the expected result
    task automatic do_op(input bit st, input logic [10:0] base, input logic [1:0] idx,
                         input logic [12:0] off, input logic [15:0] data, input logic [10:0] pc,
                         input int stall, input logic [10:0] haddr, input logic [31:0] hdata,
                         input bit ghost, input string tag);
        item_t it;
        logic [10:0] a;
        a = ea(base, off);
        if (stall > 0) shadow[int'(haddr)] = hdata;
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_base = base; req_idx = idx;
        req_off = off; req_data = data; req_pc = pc;
        it.exp_cyc  = cyc + 4 + stall;
        it.is_store = st;
        it.addr     = a;
        it.lat_tag  = (stall > 0) ? "R6 latency" : "R5 latency";
        if (st) begin
            it.exp_word  = {pc, 3'b000, idx, data};
            shadow[int'(a)] = it.exp_word;
            it.exp_rdata = last_load;
            it.rd_tag    = "R10 rdata kept";
            it.mem_tag   = {tag, " stored word"};
        end else begin
            it.exp_word  = shadow[int'(a)];
            it.exp_rdata = it.exp_word[15:0];
            last_load    = it.exp_rdata;
            it.rd_tag    = {tag, " load data"};
            it.mem_tag   = "R9 load leaves memory";
        end
        sb.push_back(it);
        @(negedge clk);
        if (ghost) begin
            req_valid = 1'b1; req_store = 1'b1; req_base = 11'd300; req_off = '0;
            req_data = 16'hDEAD;
        end else begin
            req_valid = 1'b0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (stall > 0) begin
            host_req = 1'b1; host_we = 1'b1; host_addr = haddr; host_wdata = hdata;
            repeat (stall) @(negedge clk);
            host_req = 1'b0; host_we = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        summary();
    end

    initial begin
        req_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!done && !mem_en, "R1 in reset", {30'd0, done, mem_en}, 32'd0);
        end
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_en, "R1 after reset", {30'd0, done, mem_en}, 32'd0);

        host_write(11'd10,  32'hABCD_5678);
        host_write(11'd300, 32'h1111_2222);
        host_write(11'd4,   32'h0000_0444);

        do_op(1, 11'd5,    2'd1, 13'd0,      16'h1234, 11'h7FF, 0, '0, '0, 0, "R3");
        do_op(0, 11'd3,    2'd0, 13'd8,      16'h0,    11'h001, 0, '0, '0, 0, "R4");
        do_op(0, 11'd10,   2'd2, 13'd0,      16'h0,    11'h002, 0, '0, '0, 0, "R4");
        do_op(1, 11'd2,    2'd3, 13'h1FF4,   16'hA5A5, 11'h123, 0, '0, '0, 0, "R2");
        do_op(1, 11'd100,  2'd2, 13'h0012,   16'h5A5A, 11'h0F0, 0, '0, '0, 0, "R2");
        do_op(1, 11'd2047, 2'd0, 13'd4,      16'h0F0F, 11'h400, 0, '0, '0, 0, "R2");
        do_op(0, 11'd0,    2'd1, 13'h1FFC,   16'h0,    11'h003, 0, '0, '0, 0, "R2");
        do_op(0, 11'd5,    2'd1, 13'h1FFF,   16'h0,    11'h004, 0, '0, '0, 0, "R2");
        do_op(0, 11'd200,  2'd0, 13'd0,      16'h0,    11'h005, 3, 11'd200, 32'h7777_BEEF, 0, "R6");
        do_op(1, 11'd201,  2'd1, 13'd0,      16'hC0DE, 11'h006, 2, 11'd50,  32'h0000_0001, 0, "R6");
        do_op(0, 11'd10,   2'd3, 13'd0,      16'h0,    11'h007, 0, '0, '0, 1, "R8");
        chk(bmem[300] === 32'h1111_2222, "R8 ignored request", bmem[300], 32'h1111_2222);
        chk(bmem[50] === 32'h0000_0001, "R6 host write", bmem[50], 32'h0000_0001);
        summary();
    end

endmodule